// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects interrupt requests from eight input lines and presents one interrupt output to a processor. Each level holds a pending-request bit, an in-service bit and a mask bit. Each input can be set to detect rising edges or to follow a high level. Software writes the mask and a vector base through a small register port. A non-specific end-of-interrupt command retires the most urgent service in progress.

One pulse on the acknowledge input starts a fixed two-phase sequence. In the first phase the controller captures the priority decision from a snapshot of the pending state. In the second phase it returns an 8-bit vector and moves the captured level from pending to in service. The vector takes its upper five bits from the programmed base and its lower three bits from the winning level. If no valid winner remains at the snapshot, the controller returns level 7 as a spurious vector and records no service.

Top module: `prio_intc`

## Requirements
- R1: In edge mode (trig_level bit = 0) a request bit is set at the clock edge that first samples its input high after a low sample. It stays set after the line drops, until the level is acknowledged.
- R2: In level mode (trig_level bit = 1) a request bit equals the input sampled at the previous edge. A line that drops before the acknowledge leaves nothing pending.
- R3: A request is recorded even while its level is masked. Clearing the mask bit later raises int_out in the cycle after the write.
- R4: int_out is never asserted for a level whose mask bit is set.
- R5: An acknowledge sampled while idle runs exactly two internal phases on consecutive cycles. vec_valid is high for exactly one cycle, two cycles after the clock edge that samples ack_req. An ack_req seen while a sequence runs is ignored.
- R6: The level returned is the one resolved from the state at the end of the first phase. Requests that stay pending are served by later acknowledges.
- R7: vec_out[7:3] holds bits [7:3] of the programmed base and vec_out[2:0] holds the winning level number (0 to 7). Base bits [2:0] have no effect.
- R8: At the end of the second phase the winning level's in-service bit is set and its request bit is cleared.
- R9: Level 0 has the highest priority and level 7 the lowest. A pending unmasked level wins only if no in-service bit at the same or a higher priority is set. int_out is high exactly when such a winner exists.
- R10: A pulse on eoi clears the highest-priority in-service bit that is set.
- R11: If no valid winner exists at the snapshot, vec_out[2:0] is 7 and no in-service bit is set.
- R12: Reset (synchronous, active high) clears all request and in-service bits, sets all mask bits, clears the base and deasserts int_out and vec_valid.
- R13: A write with cfg_we = 1 loads the mask from cfg_wdata when cfg_sel = 0, and loads the vector base when cfg_sel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, index = level |
| trig_level | input | 8 | Per-level trigger select: 1 = level, 0 = rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 = mask, 1 = vector base |
| cfg_wdata | input | 8 | Configuration write data |
| ack_req | input | 1 | Acknowledge request from the bus |
| eoi | input | 1 | Non-specific end-of-interrupt command |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Returned interrupt vector |
| vec_valid | output | 1 | One-cycle strobe marking vec_out valid |

## Verification
A request, mask write or end-of-interrupt changes the registered state at one clock edge. int_out follows that state with no further delay, so the bench drives stimulus on a falling edge and reads int_out at the next falling edge. The vector comes two edges after the edge that samples ack_req. The bench reads vec_valid at the first of those falling edges, where it must be low, and again at the second, where it must be high. It then counts strobes for two more cycles, which catches a duplicate or a late vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NLVL = 8;
    localparam int LVLW = $clog2(NLVL);
    localparam int VECW = 8;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_PH1  = 2'd1,
        ACK_PH2  = 2'd2
    } ack_state_e;

    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_BASE = 1'b1
    } cfg_target_e;

    typedef struct packed {
        logic            hit;
        logic [LVLW-1:0] lvl;
    } pick_t;

    function automatic pick_t first_set(input logic [NLVL-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.lvl = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVLW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [NLVL-1:0] lvl_onehot(input pick_t p);
        logic [NLVL-1:0] m;
        m = '0;
        if (p.hit) m[p.lvl] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/intc_req_bank.sv
module intc_req_bank
    import intc_pkg::*;
#(
    parameter int N = NLVL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] trig_level,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] irr
);
    logic [N-1:0] irq_q;
    logic [N-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_in;
    end

    assign rise = irq_in & ~irq_q;

    for (genvar i = 0; i < N; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)                irr[i] <= 1'b0;
            else if (trig_level[i]) irr[i] <= irq_in[i];
            else                    irr[i] <= rise[i] | (irr[i] & ~clr_mask[i]);
        end
    end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
    import intc_pkg::*;
(
    input  logic [NLVL-1:0] irr,
    input  logic [NLVL-1:0] imr,
    input  logic [NLVL-1:0] isr,
    output pick_t           winner
);
    pick_t req_top;
    pick_t svc_top;

    always_comb begin
        req_top    = first_set(irr & ~imr);
        svc_top    = first_set(isr);
        winner.lvl = req_top.lvl;
        winner.hit = req_top.hit && (!svc_top.hit || (req_top.lvl < svc_top.lvl));
    end
endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_req,
    output logic ph1,
    output logic ph2
);
    ack_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ACK_IDLE: if (ack_req) st_nx = ACK_PH1;
            ACK_PH1:  st_nx = ACK_PH2;
            ACK_PH2:  st_nx = ACK_IDLE;
            default:  st_nx = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ACK_IDLE;
        else     st <= st_nx;
    end

    assign ph1 = (st == ACK_PH1);
    assign ph2 = (st == ACK_PH2);
endmodule

// File: rtl/intc_svc_bank.sv
module intc_svc_bank
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL-1:0] set_mask,
    input  logic            eoi,
    output logic [NLVL-1:0] isr
);
    logic [NLVL-1:0] eoi_clr;

    always_comb begin
        eoi_clr = eoi ? lvl_onehot(first_set(isr)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~eoi_clr) | set_mask;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL-1:0] irq_in,
    input  logic [NLVL-1:0] trig_level,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [VECW-1:0] cfg_wdata,
    input  logic            ack_req,
    input  logic            eoi,
    output logic            int_out,
    output logic [VECW-1:0] vec_out,
    output logic            vec_valid
);
    localparam int BASEW = VECW - LVLW;
    localparam logic [LVLW-1:0] SPUR_LVL = LVLW'(NLVL - 1);

    logic [NLVL-1:0]  irr, imr, isr;
    logic [NLVL-1:0]  svc_mask;
    logic [BASEW-1:0] base_hi;
    logic             ph1, ph2;
    pick_t            winner;
    pick_t            frz;
    logic [LVLW-1:0]  ret_lvl;

    intc_req_bank #(.N(NLVL)) u_req (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .clr_mask   (svc_mask),
        .irr        (irr)
    );

    intc_resolver u_res (
        .irr    (irr),
        .imr    (imr),
        .isr    (isr),
        .winner (winner)
    );

    intc_ack_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .ack_req (ack_req),
        .ph1     (ph1),
        .ph2     (ph2)
    );

    intc_svc_bank u_svc (
        .clk      (clk),
        .rst      (rst),
        .set_mask (svc_mask),
        .eoi      (eoi),
        .isr      (isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imr     <= '1;
            base_hi <= '0;
        end else if (cfg_we) begin
            if (cfg_target_e'(cfg_sel) == CFG_MASK) imr <= cfg_wdata[NLVL-1:0];
            else                                    base_hi <= cfg_wdata[VECW-1:LVLW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      frz <= '0;
        else if (ph1) frz <= winner;
    end

    assign ret_lvl  = frz.hit ? frz.lvl : SPUR_LVL;
    assign svc_mask = ph2 ? lvl_onehot(frz) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ph2;
            if (ph2) vec_out <= {base_hi, ret_lvl};
        end
    end

    assign int_out = winner.hit;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NLVL-1:0] irr,
    input logic [NLVL-1:0] imr,
    input logic [NLVL-1:0] isr,
    input logic            ph1,
    input logic            ph2,
    input logic            frz_hit,
    input logic [LVLW-1:0] frz_lvl,
    input logic            eoi,
    input logic            int_out,
    input logic            vec_valid
);
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        int_out |-> |(irr & ~imr)); // R4
    AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
        ph1 |=> ph2); // R5
    AST_PHASE_END: assert property (@(posedge clk) disable iff (rst)
        ph2 |=> (!ph1 && !ph2)); // R5
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ph2 |=> vec_valid); // R5
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ph2)); // R5
    AST_SERVICE_SET: assert property (@(posedge clk) disable iff (rst)
        (ph2 && frz_hit) |=> isr[$past(frz_lvl)]); // R8
    AST_SPUR_NOSET: assert property (@(posedge clk) disable iff (rst)
        (ph2 && !frz_hit && !eoi) |=> ($countones(isr) == $countones($past(isr)))); // R11
    AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
        (eoi && (isr != '0) && !ph2) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> ((imr == '1) && (isr == '0) && (irr == '0) && !int_out && !vec_valid)); // R12
endmodule

bind prio_intc intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irr       (irr),
    .imr       (imr),
    .isr       (isr),
    .ph1       (ph1),
    .ph2       (ph2),
    .frz_hit   (frz.hit),
    .frz_lvl   (frz.lvl),
    .eoi       (eoi),
    .int_out   (int_out),
    .vec_valid (vec_valid)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic [7:0] trig_level;
    logic       cfg_we;
    logic       cfg_sel;
    logic [7:0] cfg_wdata;
    logic       ack_req;
    logic       eoi;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prio_intc dut (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ack_req    (ack_req),
        .eoi        (eoi),
        .int_out    (int_out),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    // {irq, trig_level, mask, base, expected int_out, expected vector}
    localparam int NV = 6;
    localparam logic [47:0] VECS [NV] = '{
        {8'h01, 8'h00, 8'h00, 8'h20, 8'h01, 8'h20},
        {8'h90, 8'h00, 8'h00, 8'h48, 8'h01, 8'h4C},
        {8'h0C, 8'h00, 8'h04, 8'hF8, 8'h01, 8'hFB},
        {8'h80, 8'h00, 8'h80, 8'h08, 8'h00, 8'h0F},
        {8'hFF, 8'hFF, 8'h01, 8'h77, 8'h01, 8'h71},
        {8'h40, 8'h00, 8'h00, 8'h38, 8'h01, 8'h3E}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_in = '0; trig_level = '0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_wdata = '0; ack_req = 1'b0; eoi = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
    endtask

    // Acknowledge with strobe timing check (R5); returns the vector.
    task automatic do_ack(input int hold, output logic [7:0] v);
        int cnt;
        ack_req = 1'b1;
        for (int k = 0; k < hold; k++) tick();
        ack_req = 1'b0;
        cnt = 0;
        v = 8'hXX;
        for (int k = 1; k <= 4; k++) begin
            if (k == 3 - hold + 1 - 1 + 0 && 0) cnt = cnt;
            tick();
            if (k == 1 && hold == 1) check("R5 no strobe one edge after ack", {7'd0, vec_valid}, 8'd0);
            if (k == 2 - (hold - 1) && hold <= 2) begin
                check("R5 strobe two edges after ack", {7'd0, vec_valid}, 8'd1);
            end
            if (vec_valid) begin
                cnt++;
                v = vec_out;
            end
        end
        check("R5 exactly one strobe", 8'(cnt), 8'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;

        // R12 reset state
        do_reset();
        check("R12 int_out after reset", {7'd0, int_out}, 8'd0);
        check("R12 vec_valid after reset", {7'd0, vec_valid}, 8'd0);
        irq_in = 8'h01;
        tick();
        check("R12 mask set after reset", {7'd0, int_out}, 8'd0);
        // R3 masked request recorded, visible after unmask
        cfg_write(1'b0, 8'h00);
        check("R3 unmask exposes held request", {7'd0, int_out}, 8'd1);
        do_ack(1, v);
        check("R7 vector with zero base", v, 8'h00);

        // R7 R9 R13 table walk
        for (int e = 0; e < NV; e++) begin
            do_reset();
            cfg_write(1'b0, VECS[e][31:24]);
            cfg_write(1'b1, VECS[e][23:16]);
            trig_level = VECS[e][39:32];
            irq_in     = VECS[e][47:40];
            tick();
            check("R4 R9 int_out for table entry", {7'd0, int_out}, VECS[e][15:8]);
            do_ack(1, v);
            check("R7 R9 R13 vector for table entry", v, VECS[e][7:0]);
            irq_in = '0;
            tick();
        end

        // R1 edge request held after line drops
        do_reset();
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h50);
        irq_in = 8'h20;
        tick();
        irq_in = 8'h00;
        tick(); tick(); tick();
        check("R1 edge request held", {7'd0, int_out}, 8'd1);
        do_ack(1, v);
        check("R1 vector of held edge request", v, 8'h55);

        // R2 R11 level request dropped before ack -> spurious, no service
        do_reset();
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h90);
        trig_level = 8'h08;
        irq_in = 8'h08;
        tick();
        check("R2 level request raises int_out", {7'd0, int_out}, 8'd1);
        irq_in = 8'h00;
        tick();
        check("R2 level request follows line", {7'd0, int_out}, 8'd0);
        do_ack(1, v);
        check("R11 spurious vector", v, 8'h97);
        irq_in = 8'h80;
        tick();
        check("R11 no service recorded for spurious", {7'd0, int_out}, 8'd1);

        // R8 R9 R10 in-service blocking and end-of-interrupt
        do_reset();
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'hA0);
        irq_in = 8'h04;
        tick();
        do_ack(1, v);
        check("R8 level 2 served", v, 8'hA2);
        check("R8 request cleared after service", {7'd0, int_out}, 8'd0);
        irq_in = 8'h24;
        tick();
        check("R9 lower level blocked by service", {7'd0, int_out}, 8'd0);
        irq_in = 8'h26;
        tick();
        check("R9 higher level preempts", {7'd0, int_out}, 8'd1);
        do_ack(1, v);
        check("R9 level 1 vector", v, 8'hA1);
        pulse_eoi();
        check("R10 first eoi leaves level 2 in service", {7'd0, int_out}, 8'd0);
        pulse_eoi();
        check("R10 second eoi unblocks level 5", {7'd0, int_out}, 8'd1);
        do_ack(1, v);
        check("R10 level 5 vector", v, 8'hA5);

        // R5 R6 ack held during sequence ignored; pending level served later
        do_reset();
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'hC8);
        irq_in = 8'h18;
        tick();
        do_ack(2, v);
        check("R6 snapshot winner level 3", v, 8'hCB);
        check("R6 level 4 blocked by level 3 service", {7'd0, int_out}, 8'd0);
        pulse_eoi();
        check("R6 level 4 still pending after eoi", {7'd0, int_out}, 8'd1);
        do_ack(1, v);
        check("R6 level 4 vector", v, 8'hCC);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule